// File: doc/BRIEF.md
# Multi-Mode Timer with Selectable Count Length

This block is a timer counter built around a small direction state machine. A per-cycle count step is produced by choosing one of four tick sources and dividing it by 1, 2, 4 or 8. The counter then advances under one of four operating modes:

- halt
- up to a programmable period value
- free-running up to a maximum set by a selectable count length
- up to the period value and back down to zero

The block raises single-cycle events when the count steps onto zero or onto the period value. A sticky overflow flag gates an interrupt request.

All tick sources are enable pulses or sampled levels in the one clock domain. The external source is a level signal. An edge detector turns it into a tick on its rising edge, or on its falling edge when the inverted source is chosen. A clear strobe returns the counter, the divider phase and the direction to their start values. It does not touch the overflow flag.

The direction state machine has four states:

- `ST_HOLD_UP` and `ST_HOLD_DN` are halted, counting up or down respectively.
- `ST_RUN_UP` and `ST_RUN_DN` are counting up or down respectively.

Its transitions are:

- **Clear** goes to `ST_RUN_UP`, or to `ST_HOLD_UP` when halted.
- **Halt** goes from a run state to the hold state of the same direction.
- **Resume** goes from a hold state to the run state of the same direction. In a mode other than up/down it goes to `ST_RUN_UP`.
- **Turn-down** goes from `ST_RUN_UP` to `ST_RUN_DN` when an up/down tick leaves the period value.
- **Turn-up** goes from `ST_RUN_DN` to `ST_RUN_UP` when a tick brings the count to zero.
- **Force-up** goes to `ST_RUN_UP` whenever the mode is up or free-running.

Top module: `cfgt_timer`

## Requirements
- R1: After reset the count is 0, the direction is up, both event pulses are low, and the overflow flag and interrupt are low. The mode is halt (`mode_sel` = 00), so ticks do not move the count.
- R2: In free-running mode (`mode_sel` = 10) the count rises by one per step and goes from its maximum to 0, setting the overflow flag. The maximum depends on `len_sel`: 00 gives FFFFh, 01 gives 0FFFh, 10 gives 03FFh and 11 gives 00FFh.
- R3: In up mode (`mode_sel` = 01) the count rises by one per step up to `period`. The step after that returns it to 0 and sets the overflow flag.
- R4: In up/down mode (`mode_sel` = 11) the count rises to `period`, then falls to 0, then rises again. `dir_down` is high from the step that leaves the period value until the step that reaches 0. Reaching 0 sets the overflow flag.
- R5: In halt mode the count and the direction are held. Returning to up/down mode continues in the held direction.
- R6: `div_sel` codes 00, 01, 10 and 11 make one count step per 1, 2, 4 and 8 selected source ticks.
- R7: `src_sel` 00 ticks on a rising edge of `ext_clk`. 01 ticks on `aux_tick`, 10 on `sys_tick`, and 11 on a falling edge of `ext_clk`. Unselected sources are ignored.
- R8: A `clr_strobe` cycle sets the count to 0, the divider phase to 0 and the direction to up at the next edge, and no step is taken in that cycle. The overflow flag is unaffected.
- R9: `irq` is high exactly when the overflow flag and `irq_en` are both high. `flag_clr` lowers the flag, except that a new overflow in the same cycle wins.
- R10: `zero_evt` is a one-cycle pulse when a step moves the count from a nonzero value to 0. `period_evt` is a one-cycle pulse when a step moves the count onto `period` in up or up/down mode.
- R11: In up or free-running mode the direction is forced to up on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_sel | input | 2 | Count length code |
| src_sel | input | 2 | Tick source code |
| div_sel | input | 2 | Divider code |
| mode_sel | input | 2 | Operating mode code |
| clr_strobe | input | 1 | Clear counter, divider phase and direction |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Lower the overflow flag |
| period | input | CNT_W | Turning value for up and up/down modes |
| ext_clk | input | 1 | External clock level, sampled |
| aux_tick | input | 1 | Auxiliary source enable pulse |
| sys_tick | input | 1 | Subsystem source enable pulse |
| count | output | CNT_W | Counter value |
| dir_down | output | 1 | High while counting down |
| zero_evt | output | 1 | Count stepped onto 0 |
| period_evt | output | 1 | Count stepped onto the period value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle:

- The count holds in halt mode, and a clear leaves 0 with the direction up.
- Up and free-running modes force the direction up, and the overflow flag rises only together with a zero count.
- The zero event is a lone pulse that comes with a zero count.
- The interrupt is never high without the flag and the enable.

Only the directed scenarios can show the values of the sequences: the exact wrap point for each length code and each period, the turn points of up/down counting, and the divider ratios. They also show which tick source is taken, that a clear resets the divider phase, and that a new overflow wins over a flag clear.

// File: rtl/cfgt_pkg.sv
`timescale 1ns/1ps
package cfgt_pkg;

    typedef enum logic [1:0] {
        LEN_16 = 2'b00,
        LEN_12 = 2'b01,
        LEN_10 = 2'b10,
        LEN_8  = 2'b11
    } len_e;

    typedef enum logic [1:0] {
        SRC_EXT     = 2'b00,
        SRC_AUX     = 2'b01,
        SRC_SYS     = 2'b10,
        SRC_EXT_INV = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        MODE_HALT = 2'b00,
        MODE_UP   = 2'b01,
        MODE_CONT = 2'b10,
        MODE_UPDN = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_HOLD_UP = 2'b00,
        ST_HOLD_DN = 2'b01,
        ST_RUN_UP  = 2'b10,
        ST_RUN_DN  = 2'b11
    } cnt_state_e;

    // Number of counter bits used by each length code
    function automatic int unsigned len_bits(len_e l);
        int unsigned b;
        unique case (l)
            LEN_16: b = 16;
            LEN_12: b = 12;
            LEN_10: b = 10;
            LEN_8:  b = 8;
        endcase
        return b;
    endfunction

    // Highest count value for a length code
    function automatic logic [31:0] len_limit(len_e l);
        return (32'd1 << len_bits(l)) - 32'd1;
    endfunction

endpackage

// File: rtl/cfgt_src_sel.sv
`timescale 1ns/1ps
module cfgt_src_sel
    import cfgt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  src_e src,
    input  logic ext_clk,
    input  logic aux_tick,
    input  logic sys_tick,
    output logic src_tick
);

    logic ext_q;
    logic ext_rise;
    logic ext_fall;

    // Previous sample of the external level for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_clk;
        end
    end

    assign ext_rise = ext_clk & ~ext_q;
    assign ext_fall = ~ext_clk & ext_q;

    always_comb begin
        unique case (src)
            SRC_EXT:     src_tick = ext_rise;
            SRC_AUX:     src_tick = aux_tick;
            SRC_SYS:     src_tick = sys_tick;
            SRC_EXT_INV: src_tick = ext_fall;
        endcase
    end

endmodule

// File: rtl/cfgt_prescale.sv
`timescale 1ns/1ps
module cfgt_prescale #(
    parameter int DIV_CODE_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [DIV_CODE_W-1:0] div_code,
    input  logic                  src_tick,
    output logic                  cnt_tick
);

    localparam int MAX_DIV = 1 << ((1 << DIV_CODE_W) - 1);
    localparam int PH_W    = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] mask;
    logic            at_last;

    assign mask     = PH_W'((32'd1 << div_code) - 32'd1);
    assign at_last  = (phase & mask) == mask;
    assign cnt_tick = src_tick & at_last & ~clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clr) begin
            phase <= '0;
        end else if (src_tick) begin
            phase <= at_last ? '0 : ((phase & mask) + PH_W'(1));
        end
    end

endmodule

// File: rtl/cfgt_count_fsm.sv
`timescale 1ns/1ps
module cfgt_count_fsm
    import cfgt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  mode_e            mode,
    input  len_e             len,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             zero_evt,
    output logic             period_evt,
    output logic             wrap_now
);

    cnt_state_e       state;
    cnt_state_e       state_nx;
    logic [CNT_W-1:0] len_max;
    logic [CNT_W-1:0] stp_cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic             stp_dn;
    logic             stp_wrap;
    logic             running;
    logic             cur_dn;
    logic             adv;

    assign len_max = CNT_W'(len_limit(len));
    assign running = (mode != MODE_HALT);
    assign cur_dn  = ((state == ST_HOLD_DN) || (state == ST_RUN_DN)) && (mode == MODE_UPDN);
    assign adv     = running & cnt_tick & ~clr;

    // One count step for the present mode and direction
    always_comb begin
        stp_cnt  = count;
        stp_dn   = 1'b0;
        stp_wrap = 1'b0;
        unique case (mode)
            MODE_HALT: begin
                stp_cnt = count;
                stp_dn  = cur_dn;
            end
            MODE_UP: begin
                if (count >= period) begin
                    stp_cnt  = '0;
                    stp_wrap = 1'b1;
                end else begin
                    stp_cnt = count + CNT_W'(1);
                end
            end
            MODE_CONT: begin
                if (count >= len_max) begin
                    stp_cnt  = '0;
                    stp_wrap = 1'b1;
                end else begin
                    stp_cnt = count + CNT_W'(1);
                end
            end
            MODE_UPDN: begin
                if (cur_dn) begin
                    if (count <= CNT_W'(1)) begin
                        stp_cnt  = '0;
                        stp_wrap = 1'b1;
                        stp_dn   = 1'b0;
                    end else begin
                        stp_cnt = count - CNT_W'(1);
                        stp_dn  = 1'b1;
                    end
                end else if (period == '0) begin
                    stp_cnt  = '0;
                    stp_wrap = 1'b1;
                end else if (count >= period) begin
                    stp_cnt = count - CNT_W'(1);
                    stp_dn  = 1'b1;
                end else begin
                    stp_cnt = count + CNT_W'(1);
                end
            end
        endcase
    end

    // Next state and next count
    always_comb begin
        state_nx = state;
        cnt_nx   = count;
        if (clr) begin
            state_nx = running ? ST_RUN_UP : ST_HOLD_UP;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                ST_HOLD_UP, ST_HOLD_DN: begin
                    if (running) begin
                        state_nx = cur_dn ? ST_RUN_DN : ST_RUN_UP;
                        if (cnt_tick) begin
                            cnt_nx   = stp_cnt;
                            state_nx = stp_dn ? ST_RUN_DN : ST_RUN_UP;
                        end
                    end
                end
                ST_RUN_UP, ST_RUN_DN: begin
                    if (!running) begin
                        state_nx = (state == ST_RUN_DN) ? ST_HOLD_DN : ST_HOLD_UP;
                    end else if (cnt_tick) begin
                        cnt_nx   = stp_cnt;
                        state_nx = stp_dn ? ST_RUN_DN : ST_RUN_UP;
                    end else begin
                        state_nx = cur_dn ? ST_RUN_DN : ST_RUN_UP;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HOLD_UP;
        end else begin
            state <= state_nx;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count      <= '0;
            zero_evt   <= 1'b0;
            period_evt <= 1'b0;
        end else begin
            count      <= cnt_nx;
            zero_evt   <= adv && (cnt_nx == '0) && (count != '0);
            period_evt <= adv && ((mode == MODE_UP) || (mode == MODE_UPDN))
                          && (cnt_nx == period) && (count != period);
        end
    end

    assign dir_down = (state == ST_HOLD_DN) || (state == ST_RUN_DN);
    assign wrap_now = adv & stp_wrap;

endmodule

// File: rtl/cfgt_timer.sv
`timescale 1ns/1ps
module cfgt_timer
    import cfgt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DIV_CODE_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            len_sel,
    input  logic [1:0]            src_sel,
    input  logic [DIV_CODE_W-1:0] div_sel,
    input  logic [1:0]            mode_sel,
    input  logic                  clr_strobe,
    input  logic                  irq_en,
    input  logic                  flag_clr,
    input  logic [CNT_W-1:0]      period,
    input  logic                  ext_clk,
    input  logic                  aux_tick,
    input  logic                  sys_tick,
    output logic [CNT_W-1:0]      count,
    output logic                  dir_down,
    output logic                  zero_evt,
    output logic                  period_evt,
    output logic                  ovf_flag,
    output logic                  irq
);

    logic src_tick;
    logic cnt_tick;
    logic wrap_now;

    cfgt_src_sel u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src_e'(src_sel)),
        .ext_clk  (ext_clk),
        .aux_tick (aux_tick),
        .sys_tick (sys_tick),
        .src_tick (src_tick)
    );

    cfgt_prescale #(.DIV_CODE_W(DIV_CODE_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_strobe),
        .div_code (div_sel),
        .src_tick (src_tick),
        .cnt_tick (cnt_tick)
    );

    cfgt_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_strobe),
        .mode       (mode_e'(mode_sel)),
        .len        (len_e'(len_sel)),
        .cnt_tick   (cnt_tick),
        .period     (period),
        .count      (count),
        .dir_down   (dir_down),
        .zero_evt   (zero_evt),
        .period_evt (period_evt),
        .wrap_now   (wrap_now)
    );

    // Sticky overflow flag; a new overflow wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (wrap_now) begin
            ovf_flag <= 1'b1;
        end else if (flag_clr) begin
            ovf_flag <= 1'b0;
        end
    end

    assign irq = ovf_flag & irq_en;

endmodule

// File: rtl/cfgt_timer_chk.sv
`timescale 1ns/1ps
module cfgt_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic             clr_strobe,
    input logic             irq_en,
    input logic [CNT_W-1:0] count,
    input logic             dir_down,
    input logic             zero_evt,
    input logic             ovf_flag,
    input logic             irq
);

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00 && !clr_strobe) |=> $stable(count));

    // R8
    clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_strobe |=> (count == '0 && !dir_down));

    // R11
    force_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01 || mode_sel == 2'b10) |=> !dir_down);

    // R2
    flag_rise_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (count == '0));

    // R10
    zero_evt_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |-> (count == '0));

    // R10
    zero_evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> !zero_evt);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || !ovf_flag) |-> !irq);

endmodule

bind cfgt_timer cfgt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .clr_strobe (clr_strobe),
    .irq_en     (irq_en),
    .count      (count),
    .dir_down   (dir_down),
    .zero_evt   (zero_evt),
    .ovf_flag   (ovf_flag),
    .irq        (irq)
);

// File: tb/tb_cfgt_timer.sv
`timescale 1ns/1ps
module tb_cfgt_timer;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       len_sel = 2'b00;
    logic [1:0]       src_sel = 2'b00;
    logic [1:0]       div_sel = 2'b00;
    logic [1:0]       mode_sel = 2'b00;
    logic             clr_strobe = 1'b0;
    logic             irq_en = 1'b0;
    logic             flag_clr = 1'b0;
    logic [CNT_W-1:0] period = '0;
    logic             ext_clk = 1'b0;
    logic             aux_tick = 1'b0;
    logic             sys_tick = 1'b0;
    logic [CNT_W-1:0] count;
    logic             dir_down;
    logic             zero_evt;
    logic             period_evt;
    logic             ovf_flag;
    logic             irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfgt_timer #(.CNT_W(CNT_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_sel    (len_sel),
        .src_sel    (src_sel),
        .div_sel    (div_sel),
        .mode_sel   (mode_sel),
        .clr_strobe (clr_strobe),
        .irq_en     (irq_en),
        .flag_clr   (flag_clr),
        .period     (period),
        .ext_clk    (ext_clk),
        .aux_tick   (aux_tick),
        .sys_tick   (sys_tick),
        .count      (count),
        .dir_down   (dir_down),
        .zero_evt   (zero_evt),
        .period_evt (period_evt),
        .ovf_flag   (ovf_flag),
        .irq        (irq)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Program fields, pulse clear and lower the flag
    task automatic setup(input logic [1:0] s, input logic [1:0] d, input logic [1:0] m,
                         input logic [1:0] l, input int p);
        src_sel    = s;
        div_sel    = d;
        mode_sel   = m;
        len_sel    = l;
        period     = CNT_W'(p);
        clr_strobe = 1'b1;
        flag_clr   = 1'b1;
        step(1);
        clr_strobe = 1'b0;
        flag_clr   = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "count", 32'(count), 0);
        check("R1", "dir_down", 32'(dir_down), 0);
        check("R1", "zero_evt", 32'(zero_evt), 0);
        check("R1", "period_evt", 32'(period_evt), 0);
        check("R1", "ovf_flag", 32'(ovf_flag), 0);
        check("R1", "irq", 32'(irq), 0);
        src_sel  = 2'b01;
        aux_tick = 1'b1;
        step(5);
        check("R1", "count held in halt", 32'(count), 0);
        aux_tick = 1'b0;
    endtask

    task automatic t_up();
        setup(2'b01, 2'b00, 2'b01, 2'b00, 5);
        irq_en   = 1'b1;
        aux_tick = 1'b1;
        step(5);
        check("R3", "count at period", 32'(count), 5);
        check("R10", "period_evt", 32'(period_evt), 1);
        check("R3", "no flag before wrap", 32'(ovf_flag), 0);
        step(1);
        check("R3", "wrap to 0", 32'(count), 0);
        check("R3", "flag at wrap", 32'(ovf_flag), 1);
        check("R10", "zero_evt", 32'(zero_evt), 1);
        check("R9", "irq enabled", 32'(irq), 1);
        step(1);
        check("R3", "count after wrap", 32'(count), 1);
        check("R10", "zero_evt single", 32'(zero_evt), 0);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        check("R9", "flag cleared", 32'(ovf_flag), 0);
        check("R9", "irq low", 32'(irq), 0);
        irq_en = 1'b0;
        step(4);
        check("R9", "flag set again", 32'(ovf_flag), 1);
        check("R9", "irq masked", 32'(irq), 0);
        step(5);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        check("R9", "set wins over clear", 32'(ovf_flag), 1);
        check("R3", "count wrapped", 32'(count), 0);
        aux_tick = 1'b0;
    endtask

    task automatic t_cont();
        for (int code = 3; code >= 0; code--) begin
            int bits;
            int mx;
            bits = (code == 0) ? 16 : (code == 1) ? 12 : (code == 2) ? 10 : 8;
            mx = (1 << bits) - 1;
            setup(2'b01, 2'b00, 2'b10, 2'(code), 0);
            aux_tick = 1'b1;
            step(mx);
            check("R2", "count at length max", 32'(count), 32'(mx));
            check("R2", "no flag before rollover", 32'(ovf_flag), 0);
            step(1);
            check("R2", "rollover to 0", 32'(count), 0);
            check("R2", "flag at rollover", 32'(ovf_flag), 1);
            check("R10", "no period_evt in free-running", 32'(period_evt), 0);
            check("R11", "dir up", 32'(dir_down), 0);
            aux_tick = 1'b0;
        end
    endtask

    task automatic t_updn();
        int exp_c [7] = '{1, 2, 3, 2, 1, 0, 1};
        int exp_d [7] = '{0, 0, 0, 1, 1, 0, 0};
        setup(2'b01, 2'b00, 2'b11, 2'b00, 3);
        aux_tick = 1'b1;
        for (int i = 0; i < 7; i++) begin
            step(1);
            check("R4", "updn count", 32'(count), 32'(exp_c[i]));
            check("R4", "updn dir", 32'(dir_down), 32'(exp_d[i]));
            if (i == 2) check("R10", "period_evt at peak", 32'(period_evt), 1);
            if (i == 4) check("R4", "no flag before 0", 32'(ovf_flag), 0);
            if (i == 5) check("R4", "flag at 0", 32'(ovf_flag), 1);
        end
        step(3);
        check("R4", "descending again", 32'(count), 2);
        check("R4", "dir down", 32'(dir_down), 1);
        mode_sel = 2'b00;
        step(3);
        check("R5", "count held", 32'(count), 2);
        check("R5", "dir held", 32'(dir_down), 1);
        mode_sel = 2'b11;
        step(1);
        check("R5", "resume down", 32'(count), 1);
        check("R5", "resume dir", 32'(dir_down), 1);
        clr_strobe = 1'b1;
        step(1);
        clr_strobe = 1'b0;
        check("R8", "clear count", 32'(count), 0);
        check("R8", "clear dir", 32'(dir_down), 0);
        check("R8", "flag kept", 32'(ovf_flag), 1);
        step(4);
        check("R4", "down phase", 32'(dir_down), 1);
        mode_sel = 2'b01;
        step(1);
        check("R11", "count in up", 32'(count), 3);
        check("R11", "dir forced up", 32'(dir_down), 0);
        aux_tick = 1'b0;
    endtask

    task automatic t_div();
        for (int d = 1; d <= 3; d++) begin
            int n;
            n = 1 << d;
            setup(2'b01, 2'(d), 2'b01, 2'b00, 1000);
            aux_tick = 1'b1;
            step(2 * n - 1);
            check("R6", "one step", 32'(count), 1);
            step(1);
            check("R6", "two steps", 32'(count), 2);
            step(n - 1);
            clr_strobe = 1'b1;
            step(1);
            clr_strobe = 1'b0;
            check("R8", "clear mid phase", 32'(count), 0);
            step(n - 1);
            check("R8", "phase reset", 32'(count), 0);
            step(1);
            check("R8", "first step after clear", 32'(count), 1);
            aux_tick = 1'b0;
        end
    endtask

    task automatic t_src();
        ext_clk = 1'b0;
        step(1);
        setup(2'b00, 2'b00, 2'b01, 2'b00, 1000);
        aux_tick = 1'b1;
        sys_tick = 1'b1;
        step(2);
        check("R7", "pulse sources ignored", 32'(count), 0);
        ext_clk = 1'b1;
        step(1);
        check("R7", "rising edge", 32'(count), 1);
        step(1);
        check("R7", "steady high", 32'(count), 1);
        ext_clk = 1'b0;
        step(1);
        check("R7", "falling ignored", 32'(count), 1);
        setup(2'b11, 2'b00, 2'b01, 2'b00, 1000);
        ext_clk = 1'b1;
        step(1);
        check("R7", "inverted rising ignored", 32'(count), 0);
        ext_clk = 1'b0;
        step(1);
        check("R7", "inverted falling", 32'(count), 1);
        setup(2'b10, 2'b00, 2'b01, 2'b00, 1000);
        sys_tick = 1'b0;
        aux_tick = 1'b1;
        step(3);
        check("R7", "aux ignored on sys", 32'(count), 0);
        sys_tick = 1'b1;
        step(3);
        check("R7", "sys counted", 32'(count), 3);
        setup(2'b01, 2'b00, 2'b01, 2'b00, 1000);
        aux_tick = 1'b0;
        step(3);
        check("R7", "sys ignored on aux", 32'(count), 0);
        aux_tick = 1'b1;
        step(2);
        check("R7", "aux counted", 32'(count), 2);
        aux_tick = 1'b0;
        sys_tick = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_up();
        t_cont();
        t_updn();
        t_div();
        t_src();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule